// File: doc/BRIEF.md
# FPGA Configuration Control Sequencer

This block is the state machine that walks a programmable device through its configuration. A run starts in one of two ways. Either the I/O supply-good and core supply-good flags both become true, or the active-low reprogram input is pulled low. The sequencer first acknowledges the start by pulling the init line low and holding DONE low. It then waits for as long as reprogram is held low, and asks the memory-clear engine to clear configuration memory. After the clear, it waits for as long as an outside agent holds the open-drain init line low. It samples the mode pins once, and asks the frame loader to load the data frames in the sampled mode.

When the loader finishes, the loader reports a CRC verdict. A bad CRC sends the sequencer to an abort state, where it pulls init low and stays. A good CRC starts the start-up sequence, which takes three cycles: DONE goes high, then the user I/Os are enabled, then global set/reset is released. The memory-clear and start-up phases are the same in every mode. Only the frame loading depends on the captured mode, and that happens outside this block.

States: `CS_OFF` (supplies not good), `CS_ACK` (start acknowledged), `CS_PROG_HOLD` (reprogram held), `CS_CLEAR` (memory clear), `CS_INIT_HOLD` (external init hold), `CS_MODE` (mode capture), `CS_LOAD` (frame loading), `CS_ABORT` (CRC failure), `CS_SU_DONE`, `CS_SU_IO`, `CS_USER`.

Transitions:
- Any state goes to `CS_OFF` when supply-good is lost.
- Any state except `CS_OFF`, `CS_ACK` and `CS_PROG_HOLD` goes to `CS_ACK` when the synchronized reprogram input is low.
- `CS_OFF` goes to `CS_ACK`.
- `CS_ACK` goes to `CS_PROG_HOLD`.
- `CS_PROG_HOLD` goes to `CS_CLEAR` once reprogram is high.
- `CS_CLEAR` goes to `CS_INIT_HOLD` on clear done.
- `CS_INIT_HOLD` goes to `CS_MODE` once init is high.
- `CS_MODE` goes to `CS_LOAD`.
- `CS_LOAD` goes to `CS_SU_DONE` when load done arrives with a good CRC, and to `CS_ABORT` when it arrives with a bad CRC.
- `CS_SU_DONE` goes to `CS_SU_IO`, which goes to `CS_USER`.
- `CS_ABORT` and `CS_USER` stay where they are.

Top module: `cfg_sequencer`

## Requirements
- R1: Configuration starts only when `pwr_io_ok` and `pwr_core_ok` are both high after synchronization. While only one of them is high, `clear_start` stays low and `init_pull` stays high.
- R2: On every start, whether from supply-good or from reprogram, `cfg_done` is low and `init_pull` is high. A reprogram assertion returns the sequencer to that acknowledge state from any later state, user operation included.
- R3: While `reprog_n` is held low, the sequencer stays in its reprogram hold. In that hold `clear_start` is low, `init_pull` is high and `cfg_done` is low.
- R4: After `reprog_n` goes high, `clear_start` is held high until `clear_done` is seen. `init_pull` stays high throughout the clear.
- R5: After the clear, `init_pull` is released. `init_level` is the wired-AND of the block's release and `init_hold_n`. The sequencer waits for as long as `init_hold_n` is low.
- R6: The mode pins are captured into `load_mode` only in the one cycle after init is seen high, and `load_mode` holds that value at all other times (reset value 0). `load_start` is then held high until `load_done`.
- R7: `load_done` with `crc_ok`=0 enters abort. In abort, `init_pull` is high and `cfg_done` is low. Abort is held until reprogram or loss of supply-good.
- R8: `load_done` with `crc_ok`=1 starts start-up. In the first cycle only `cfg_done` is high. In the second cycle `io_en` is added. In the third cycle `gsr_release` is added, and all three stay high.
- R9: Loss of either supply-good flag from any state returns to the power-off state, with `init_pull` high. The whole sequence restarts when supply-good returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_io_ok | input | 1 | I/O supply good (asynchronous) |
| pwr_core_ok | input | 1 | Core supply good (asynchronous) |
| reprog_n | input | 1 | Active-low reprogram request (asynchronous) |
| init_hold_n | input | 1 | Externally driven level of the open-drain init line, low = hold |
| mode_pins | input | MODE_W | Configuration mode pins |
| clear_done | input | 1 | Memory-clear engine finished (synchronous) |
| load_done | input | 1 | Frame loader finished (synchronous) |
| crc_ok | input | 1 | CRC verdict, valid with load_done |
| init_pull | output | 1 | Block pulls the init line low |
| init_level | output | 1 | Resolved wired-AND level of the init line |
| cfg_done | output | 1 | DONE indicator |
| io_en | output | 1 | User I/O enable |
| gsr_release | output | 1 | Global set/reset released |
| clear_start | output | 1 | Memory-clear request, held until clear_done |
| load_start | output | 1 | Frame-load request, held until load_done |
| load_mode | output | MODE_W | Mode captured for frame loading |

## Verification
The assertions assume that `load_done` and `clear_done` are single-cycle signals in the sequencer's clock domain, and that `crc_ok` is valid in the same cycle as `load_done`. They also assume that supply and reprogram changes are slow compared with the two-stage synchronizer. The stimulus follows these rules. Every asynchronous input is changed on a falling edge and then left alone for several cycles before any output is checked. Handshake pulses are one cycle long and are only given in the state that waits for them. The start-up ordering and the CRC abort are checked cycle by cycle from the edge that takes the verdict.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [3:0] {
        CS_OFF,
        CS_ACK,
        CS_PROG_HOLD,
        CS_CLEAR,
        CS_INIT_HOLD,
        CS_MODE,
        CS_LOAD,
        CS_ABORT,
        CS_SU_DONE,
        CS_SU_IO,
        CS_USER
    } cfg_state_e;

    typedef struct packed {
        logic init_pull;
        logic done;
        logic io_en;
        logic gsr_release;
        logic clear_start;
        logic load_start;
        logic mode_cap;
    } cfg_ctl_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= RST_VAL;
            end else if (s == 0) begin
                chain[s] <= din;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/cfg_mode_capture.sv
module cfg_mode_capture #(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [MODE_W-1:0] mode_in,
    output logic [MODE_W-1:0] mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (cap_en) begin
            mode_q <= mode_in;
        end
    end

endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
    import cfg_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pwr_ok,
    input  logic     reprog_s_n,
    input  logic     init_s,
    input  logic     clear_done,
    input  logic     load_done,
    input  logic     crc_ok,
    output cfg_ctl_t ctl
);

    cfg_state_e state, nxt;
    logic       early;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CS_OFF;
        end else begin
            state <= nxt;
        end
    end

    // states that a reprogram request does not interrupt
    assign early = (state == CS_OFF) || (state == CS_ACK) || (state == CS_PROG_HOLD);

    // next-state logic
    always_comb begin
        nxt = state;
        if (!pwr_ok) begin
            nxt = CS_OFF;
        end else if (!reprog_s_n && !early) begin
            nxt = CS_ACK;
        end else begin
            unique case (state)
                CS_OFF:       nxt = CS_ACK;
                CS_ACK:       nxt = CS_PROG_HOLD;
                CS_PROG_HOLD: if (reprog_s_n) nxt = CS_CLEAR;
                CS_CLEAR:     if (clear_done) nxt = CS_INIT_HOLD;
                CS_INIT_HOLD: if (init_s) nxt = CS_MODE;
                CS_MODE:      nxt = CS_LOAD;
                CS_LOAD:      if (load_done) nxt = crc_ok ? CS_SU_DONE : CS_ABORT;
                CS_ABORT:     nxt = CS_ABORT;
                CS_SU_DONE:   nxt = CS_SU_IO;
                CS_SU_IO:     nxt = CS_USER;
                CS_USER:      nxt = CS_USER;
                default:      nxt = CS_OFF;
            endcase
        end
    end

    // output decode
    always_comb begin
        ctl = '0;
        unique case (state)
            CS_OFF, CS_ACK, CS_PROG_HOLD, CS_ABORT: begin
                ctl.init_pull = 1'b1;
            end
            CS_CLEAR: begin
                ctl.init_pull   = 1'b1;
                ctl.clear_start = 1'b1;
            end
            CS_INIT_HOLD: begin
                ctl.init_pull = 1'b0;
            end
            CS_MODE: begin
                ctl.mode_cap = (nxt == CS_LOAD);
            end
            CS_LOAD: begin
                ctl.load_start = 1'b1;
            end
            CS_SU_DONE: begin
                ctl.done = 1'b1;
            end
            CS_SU_IO: begin
                ctl.done  = 1'b1;
                ctl.io_en = 1'b1;
            end
            CS_USER: begin
                ctl.done        = 1'b1;
                ctl.io_en       = 1'b1;
                ctl.gsr_release = 1'b1;
            end
            default: begin
                ctl.init_pull = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
    import cfg_seq_pkg::*;
#(
    parameter int MODE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_io_ok,
    input  logic              pwr_core_ok,
    input  logic              reprog_n,
    input  logic              init_hold_n,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              clear_done,
    input  logic              load_done,
    input  logic              crc_ok,
    output logic              init_pull,
    output logic              init_level,
    output logic              cfg_done,
    output logic              io_en,
    output logic              gsr_release,
    output logic              clear_start,
    output logic              load_start,
    output logic [MODE_W-1:0] load_mode
);

    localparam int ASYNC_W = 4;

    logic [ASYNC_W-1:0] async_raw, async_s;
    cfg_ctl_t           ctl;

    assign async_raw = {pwr_io_ok, pwr_core_ok, reprog_n, init_hold_n};

    cfg_sync #(
        .WIDTH  (ASYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0011)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (async_raw),
        .dout (async_s)
    );

    cfg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (async_s[3] & async_s[2]),
        .reprog_s_n(async_s[1]),
        .init_s    (async_s[0]),
        .clear_done(clear_done),
        .load_done (load_done),
        .crc_ok    (crc_ok),
        .ctl       (ctl)
    );

    cfg_mode_capture #(
        .MODE_W(MODE_W)
    ) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (ctl.mode_cap),
        .mode_in(mode_pins),
        .mode_q (load_mode)
    );

    // open-drain init line: released by the block AND released externally
    assign init_pull   = ctl.init_pull;
    assign init_level  = ~ctl.init_pull & init_hold_n;
    assign cfg_done    = ctl.done;
    assign io_en       = ctl.io_en;
    assign gsr_release = ctl.gsr_release;
    assign clear_start = ctl.clear_start;
    assign load_start  = ctl.load_start;

endmodule

// File: rtl/cfg_sequencer_chk.sv
module cfg_sequencer_chk #(
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_pull,
    input logic              init_level,
    input logic              cfg_done,
    input logic              io_en,
    input logic              gsr_release,
    input logic              clear_start,
    input logic              load_start,
    input logic              load_done,
    input logic              crc_ok,
    input logic [MODE_W-1:0] load_mode
);

    AST_IO_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> cfg_done); // R8
    AST_GSR_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        gsr_release |-> io_en); // R8
    AST_IO_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_en) |-> $past(cfg_done)); // R8
    AST_CLEAR_HOLDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        clear_start |-> (init_pull && !cfg_done)); // R4
    AST_PULL_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        init_pull |-> !init_level); // R5
    AST_MODE_ONLY_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(load_mode) |-> load_start); // R6
    AST_CRC_BAD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_start && load_done && !crc_ok) |=> (init_pull && !cfg_done)); // R7

endmodule

bind cfg_sequencer cfg_sequencer_chk #(.MODE_W(MODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_pull  (init_pull),
    .init_level (init_level),
    .cfg_done   (cfg_done),
    .io_en      (io_en),
    .gsr_release(gsr_release),
    .clear_start(clear_start),
    .load_start (load_start),
    .load_done  (load_done),
    .crc_ok     (crc_ok),
    .load_mode  (load_mode)
);

// File: tb/cfg_sequencer_test.sv
module cfg_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int MODE_W     = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              pwr_io_ok, pwr_core_ok, reprog_n, init_hold_n;
    logic [MODE_W-1:0] mode_pins;
    logic              clear_done, load_done, crc_ok;
    logic              init_pull, init_level, cfg_done, io_en, gsr_release;
    logic              clear_start, load_start;
    logic [MODE_W-1:0] load_mode;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // scoreboard queues: vector = {init_level, done, io_en, gsr, clear_start, load_start, init_pull}
    logic [6:0]        q_vec[$];
    logic [MODE_W-1:0] q_mode[$];
    string             q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_sequencer #(.MODE_W(MODE_W)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_io_ok(pwr_io_ok), .pwr_core_ok(pwr_core_ok),
        .reprog_n(reprog_n), .init_hold_n(init_hold_n), .mode_pins(mode_pins),
        .clear_done(clear_done), .load_done(load_done), .crc_ok(crc_ok),
        .init_pull(init_pull), .init_level(init_level), .cfg_done(cfg_done),
        .io_en(io_en), .gsr_release(gsr_release), .clear_start(clear_start),
        .load_start(load_start), .load_mode(load_mode)
    );

    // expectation applies to outputs after the next rising edge
    task automatic expect_out(input logic [6:0] v, input logic [MODE_W-1:0] m, input string tag);
        q_vec.push_back(v);
        q_mode.push_back(m);
        q_tag.push_back(tag);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (q_vec.size() > 0) begin
                logic [6:0]        ev;
                logic [MODE_W-1:0] em;
                logic [6:0]        av;
                string             t;
                ev = q_vec.pop_front();
                em = q_mode.pop_front();
                t  = q_tag.pop_front();
                av = {init_level, cfg_done, io_en, gsr_release, clear_start, load_start, init_pull};
                checks++;
                if (av !== ev || load_mode !== em) begin
                    fails++;
                    $display("FAIL %s: got vec=%b mode=%0d, expected vec=%b mode=%0d",
                             t, av, load_mode, ev, em);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; pwr_io_ok = 0; pwr_core_ok = 0; reprog_n = 1; init_hold_n = 1;
        mode_pins = '0; clear_done = 0; load_done = 0; crc_ok = 0;
        tick(2);
        expect_out(7'b0000001, 3'd0, "R1 reset state");
        tick(2);
        rst_n = 1;
        // R1: only one supply good -> stays off
        pwr_io_ok = 1;
        tick(8);
        expect_out(7'b0000001, 3'd0, "R1 single supply no start");
        tick(2);
        // R3: both good but reprogram held
        reprog_n = 0; pwr_core_ok = 1;
        tick(8);
        expect_out(7'b0000001, 3'd0, "R3 reprogram hold");
        tick(2);
        // R4: release -> clear requested
        reprog_n = 1;
        tick(8);
        expect_out(7'b0000101, 3'd0, "R4 clear request");
        tick(2);
        // R5: external init hold after clear
        init_hold_n = 0;
        tick(4);
        clear_done = 1;
        tick(1);
        clear_done = 0;
        mode_pins = 3'd2;
        tick(6);
        expect_out(7'b0000000, 3'd0, "R5 init held externally, R6 mode not sampled");
        tick(2);
        // R6: release init -> mode captured, load requested
        init_hold_n = 1;
        tick(8);
        expect_out(7'b1000010, 3'd2, "R6 load request with mode 2");
        tick(2);
        mode_pins = 3'd1;
        tick(4);
        expect_out(7'b1000010, 3'd2, "R6 mode held after capture");
        tick(2);
        // R8: start-up order, cycle by cycle
        load_done = 1; crc_ok = 1;
        expect_out(7'b1100000, 3'd2, "R8 startup cycle 1");
        tick(1);
        load_done = 0; crc_ok = 0;
        expect_out(7'b1110000, 3'd2, "R8 startup cycle 2");
        tick(1);
        expect_out(7'b1111000, 3'd2, "R8 startup cycle 3");
        tick(4);
        expect_out(7'b1111000, 3'd2, "R8 user operation held");
        tick(2);
        // R2: reprogram from user operation
        reprog_n = 0;
        tick(8);
        expect_out(7'b0000001, 3'd2, "R2 reprogram ack from user");
        tick(2);
        reprog_n = 1;
        tick(8);
        expect_out(7'b0000101, 3'd2, "R4 second clear");
        tick(2);
        clear_done = 1;
        tick(1);
        clear_done = 0;
        tick(8);
        expect_out(7'b1000010, 3'd1, "R6 second load with mode 1");
        tick(2);
        // R7: CRC failure aborts
        load_done = 1; crc_ok = 0;
        expect_out(7'b0000001, 3'd1, "R7 abort on bad CRC");
        tick(1);
        load_done = 0;
        tick(3);
        load_done = 1;
        tick(1);
        load_done = 0;
        tick(6);
        expect_out(7'b0000001, 3'd1, "R7 abort held");
        tick(2);
        // R9: supply loss restarts
        pwr_core_ok = 0;
        tick(6);
        expect_out(7'b0000001, 3'd1, "R9 power lost");
        tick(2);
        pwr_core_ok = 1;
        tick(8);
        expect_out(7'b0000101, 3'd1, "R9 restart reaches clear");
        tick(4);
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule